// File: doc/BRIEF.md
# Function Power-State Register Unit

This block sits in the configuration space of an interrupt-controller function and holds the function's two-bit device power state. It offers two 16-bit registers behind a simple configuration port. The port carries a request strobe, a write flag, a byte offset, byte enables and write data. One register is a read-only capability word. The other is a control word, and software sets the power state through it.

The stored state decides what the function may do. In the deep low-power state (D3hot), the block refuses memory-space accesses and drops message-signalled interrupt requests. Legacy wire interrupts pass through unchanged in every state. A write that names a reserved state code completes as usual, but the state does not change. Returning from D3hot to D0 has no side effect on anything else.

Top module: `pwr_state_unit`

## Requirements
- R1: After synchronous active-low reset, the power state is D0 (00b). A read of the capability register at offset 6Eh returns 0002h. A read of the control register at offset 70h returns 0000h.
- R2: The capability register at 6Eh always reads 0002h. Bits 2:0 hold version 010b and bits 15:3 are zero. Writes to it have no effect.
- R3: A write to offset 70h with byte enable bit 0 set loads bits 1:0 of the write data into the power state, provided the code is 00b (D0) or 11b (D3hot). The other read-back bits of offset 70h read zero.
- R4: A write to offset 70h that carries code 01b or 10b leaves the power state unchanged.
- R5: A write to offset 70h with byte enable bit 0 clear leaves the power state unchanged.
- R6: A read returns its data, with the read-valid strobe high for one cycle, on the cycle after the request. Unmapped offsets read 0000h.
- R7: While the state is 11b, the memory-access gate output is low and the D3hot status output is high. In D0, the gate output is high and the status output is low.
- R8: While the state is 11b, the MSI output is low whatever the MSI request input does. In D0, the MSI output follows the request input.
- R9: The wire-interrupt outputs equal the wire-interrupt inputs in every power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Configuration access request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Byte offset of the 16-bit register |
| cfg_be | input | 2 | Byte enables |
| cfg_wdata | input | 16 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the request |
| cfg_rdata | output | 16 | Read data |
| mem_access_en | output | 1 | High when memory-space accesses may be serviced |
| in_d3hot | output | 1 | High while in D3hot |
| msi_req_in | input | 1 | MSI request from the interrupt logic |
| msi_req_out | output | 1 | Gated MSI request |
| wire_irq_in | input | 4 | Virtual-wire interrupt inputs |
| wire_irq_out | output | 4 | Virtual-wire interrupt outputs |

## Verification
A wrong stored state shows up at the gate outputs in the same cycle. If the state is corrupted, the memory gate, the D3hot flag and the MSI pass-through all flip at once, right after the write edge that caused it. The bench compares all of them against its own model of the state. A write filter that accepts a reserved code is visible on the next read of offset 70h, one cycle after the read request. A faulty decode shows as nonzero data, or a missing valid strobe, on that same read cycle.

// File: rtl/pwr_state_pkg.sv
// Shared definitions for the power-state register unit.
// Assumes 16-bit registers addressed by byte offset.
package pwr_state_pkg;
    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_RSV1  = 2'b01,
        PS_RSV2  = 2'b10,
        PS_D3HOT = 2'b11
    } pstate_e;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 8;
    localparam int BE_W   = REG_W / 8;

    // True for the state codes this function supports.
    function automatic logic pstate_supported(input logic [1:0] code);
        return (code == PS_D0) || (code == PS_D3HOT);
    endfunction
endpackage

// File: rtl/pwr_state_store.sv
// Holds the two-bit power state. A new code is loaded only when a qualified
// write presents a supported code; reserved codes are dropped.
// Assumes the caller has already decoded the address and the low byte enable.
module pwr_state_store
    import pwr_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [1:0] wr_code,
    output pstate_e    state
);
    // Filtered state register; reset forces D0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= PS_D0;
        else if (wr_hit && pstate_supported(wr_code))
            state <= pstate_e'(wr_code);
    end

    // Only reachable codes are held in the register.
    p_state_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pstate_supported(state));

    // A reserved code never changes the state.
    p_rsv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !pstate_supported(wr_code)) |=> $stable(state));

    // With no qualified write, the state holds.
    p_nowr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(state));
endmodule

// File: rtl/pwr_cfg_port.sv
// Configuration decode: qualifies writes to the control word and returns
// registered read data one cycle after a read request.
// Assumes one access per cycle and no backpressure.
module pwr_cfg_port
    import pwr_state_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CAP_OFS  = 8'h6E,
    parameter logic [ADDR_W-1:0] CTL_OFS  = 8'h70,
    parameter logic [2:0]        CAP_VERS = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  pstate_e           state,
    output logic              wr_hit,
    output logic [1:0]        wr_code,
    output logic              cfg_rvalid,
    output logic [REG_W-1:0]  cfg_rdata
);
    logic [REG_W-1:0] rd_mux;

    // Write qualification for the state field in the low byte.
    always_comb begin
        wr_hit  = cfg_req && cfg_wr && (cfg_addr == CTL_OFS) && cfg_be[0];
        wr_code = cfg_wdata[1:0];
    end

    // Read data selection by offset; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (cfg_addr == CAP_OFS)
            rd_mux = {{(REG_W-3){1'b0}}, CAP_VERS};
        else if (cfg_addr == CTL_OFS)
            rd_mux = {{(REG_W-2){1'b0}}, state};
    end

    // Read response register: data and valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_req && !cfg_wr;
            cfg_rdata  <= (cfg_req && !cfg_wr) ? rd_mux : '0;
        end
    end

    p_rvalid_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_wr) |=> cfg_rvalid);

    p_cap_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_wr && cfg_addr == CAP_OFS) |=> (cfg_rdata == 16'h0002));
endmodule

// File: rtl/pwr_gate.sv
// Side-band gating driven from the stored power state: memory access and
// MSI are blocked in D3hot; wire interrupts pass in every state.
// Assumes a purely combinational path is acceptable for the gates.
module pwr_gate
    import pwr_state_pkg::*;
#(
    parameter int N_WIRE = 4
) (
    input  pstate_e           state,
    input  logic              msi_req_in,
    input  logic [N_WIRE-1:0] wire_irq_in,
    output logic              in_d3hot,
    output logic              mem_access_en,
    output logic              msi_req_out,
    output logic [N_WIRE-1:0] wire_irq_out
);
    // Gate decode from the current state.
    always_comb begin
        in_d3hot      = (state == PS_D3HOT);
        mem_access_en = !in_d3hot;
        msi_req_out   = msi_req_in && !in_d3hot;
    end

    // Per-line pass-through of the virtual wires.
    for (genvar g = 0; g < N_WIRE; g++) begin : g_wire
        assign wire_irq_out[g] = wire_irq_in[g];
    end

    always_comb begin
        a_msi_block_r8: assert (!(state == PS_D3HOT && msi_req_out));
    end
endmodule

// File: rtl/pwr_state_unit.sv
// Top of the power-state register unit: config port, filtered state store
// and gating. Assumes a single clock domain and synchronous active-low reset.
module pwr_state_unit
    import pwr_state_pkg::*;
#(
    parameter int N_WIRE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [1:0]        cfg_be,
    input  logic [15:0]       cfg_wdata,
    output logic              cfg_rvalid,
    output logic [15:0]       cfg_rdata,
    output logic              mem_access_en,
    output logic              in_d3hot,
    input  logic              msi_req_in,
    output logic              msi_req_out,
    input  logic [N_WIRE-1:0] wire_irq_in,
    output logic [N_WIRE-1:0] wire_irq_out
);
    pstate_e    state;
    logic       wr_hit;
    logic [1:0] wr_code;

    pwr_cfg_port u_port (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .state(state), .wr_hit(wr_hit), .wr_code(wr_code),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
    );

    pwr_state_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_code(wr_code),
        .state(state)
    );

    pwr_gate #(.N_WIRE(N_WIRE)) u_gate (
        .state(state), .msi_req_in(msi_req_in), .wire_irq_in(wire_irq_in),
        .in_d3hot(in_d3hot), .mem_access_en(mem_access_en),
        .msi_req_out(msi_req_out), .wire_irq_out(wire_irq_out)
    );

    p_gate_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_access_en != in_d3hot);

    p_wire_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wire_irq_out == wire_irq_in);

    p_reset_d0_r1: assert property (@(posedge clk)
        !rst_n |=> !in_d3hot);
endmodule

// File: tb/test_pwr_state_unit.sv
module test_pwr_state_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_req = 0, cfg_wr = 0;
    logic [7:0]  cfg_addr = 0;
    logic [1:0]  cfg_be = 0;
    logic [15:0] cfg_wdata = 0;
    logic        cfg_rvalid, mem_access_en, in_d3hot, msi_req_out;
    logic [15:0] cfg_rdata;
    logic        msi_req_in = 0;
    logic [3:0]  wire_irq_in = 0, wire_irq_out;

    int n_cmp = 0, n_bad = 0;
    logic [1:0] model = 2'b00;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_state_unit i_pwr_state_unit (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .mem_access_en(mem_access_en), .in_d3hot(in_d3hot),
        .msi_req_in(msi_req_in), .msi_req_out(msi_req_out),
        .wire_irq_in(wire_irq_in), .wire_irq_out(wire_irq_out)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge; it is taken at the next rising edge.
    task automatic cfg_write(logic [7:0] a, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        cfg_req = 1; cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 0; cfg_wr = 0;
    endtask

    task automatic cfg_read(logic [7:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        cfg_req = 1; cfg_wr = 0; cfg_addr = a; cfg_be = 2'b11;
        @(negedge clk);
        cfg_req = 0;
        d = cfg_rdata; v = cfg_rvalid;
    endtask

    task automatic check_gates(string req);
        check(req, {15'd0, in_d3hot}, {15'd0, model == 2'b11});
        check(req, {15'd0, mem_access_en}, {15'd0, model != 2'b11});
    endtask

    task automatic t_reset();
        logic [15:0] d; logic v;
        cfg_read(8'h6E, d, v);
        check("R1 cap", d, 16'h0002);
        check("R6 valid", {15'd0, v}, 16'd1);
        cfg_read(8'h70, d, v);
        check("R1 ctl", d, 16'h0000);
        check_gates("R1");
    endtask

    task automatic t_state_writes();
        logic [15:0] d; logic v;
        cfg_write(8'h70, 2'b01, 16'hFFFF); model = 2'b11;
        cfg_read(8'h70, d, v);
        check("R3 d3 read", d, 16'h0003);
        check_gates("R7 d3");
        cfg_write(8'h70, 2'b01, 16'h0001);
        cfg_read(8'h70, d, v);
        check("R4 rsv01", d, 16'h0003);
        cfg_write(8'h70, 2'b01, 16'h0000); model = 2'b00;
        cfg_read(8'h70, d, v);
        check("R3 d0", d, 16'h0000);
        check_gates("R7 d0");
        cfg_write(8'h70, 2'b01, 16'h0002);
        cfg_read(8'h70, d, v);
        check("R4 rsv10", d, 16'h0000);
        cfg_write(8'h70, 2'b10, 16'h0003);
        cfg_read(8'h70, d, v);
        check("R5 be0 clear", d, 16'h0000);
        check_gates("R5");
    endtask

    task automatic t_decode();
        logic [15:0] d; logic v;
        cfg_write(8'h6E, 2'b11, 16'hFFFF);
        cfg_read(8'h6E, d, v);
        check("R2 cap ro", d, 16'h0002);
        cfg_read(8'h40, d, v);
        check("R6 unmapped", d, 16'h0000);
        check("R6 valid", {15'd0, v}, 16'd1);
        @(negedge clk);
        check("R6 pulse", {15'd0, cfg_rvalid}, 16'd0);
    endtask

    task automatic t_irq();
        for (int s = 0; s < 2; s++) begin
            model = s ? 2'b11 : 2'b00;
            cfg_write(8'h70, 2'b01, {14'd0, model});
            for (int p = 0; p < 4; p++) begin
                msi_req_in = p[0]; wire_irq_in = 4'(p * 5 + s);
                #1;
                check("R8 msi", {15'd0, msi_req_out}, {15'd0, p[0] && !s});
                check("R9 wire", {12'd0, wire_irq_out}, {12'd0, wire_irq_in});
            end
        end
        msi_req_in = 0;
    endtask

    task automatic t_reset_return();
        logic [15:0] d; logic v;
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; model = 2'b00;
        check_gates("R1 rereset");
        cfg_read(8'h70, d, v);
        check("R1 rereset ctl", d, 16'h0000);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_state_writes();
        t_decode();
        t_irq();
        t_reset_return();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule